// File: doc/BRIEF.md
# Chip-Select Output Controller

This block drives a small bank of general-purpose output pins, any of which can serve as the chip select of an attached serial peripheral. Each pin has one stored level bit. A single level-control write word changes any mix of pins at once, with no read-modify-write: a one in the upper byte raises a pin's level and a one in the lower byte lowers it. Pins with neither bit set in that word keep their level. A select is asserted by lowering its level and released by raising it. Selects are numbered from 1, and select n uses bit n-1 of each byte.

A configuration word gives each pin two bits. The upper byte marks the pin as used for chip select, and that mark is passed on to the neighbouring logic. The lower byte inverts the pin's output, which turns an active-low select into an active-high one. The pin drives its stored level XOR its invert bit. Software writes 0xFF00 at start-up to release every select. The level bits reset to that same released state, and the configuration resets to zero.

A parameter picks the variant: the wide variant implements 6 selects and the narrow one implements 3. Pins above the implemented count are fixed. They ignore all writes, hold level 1, read back 0 in configuration and drive 1.

Top module: `cs_out_ctrl`

## Requirements
- R1: After reset, every stored level reads 1, the configuration readback is 0x0000, every pin drives 1 and no pin is marked for chip-select use.
- R2: A level write with bit 8+i set (for an implemented pin i) makes that pin's level 1 from the next clock edge.
- R3: A level write with bit i set and bit 8+i clear makes level i equal 0 from the next clock edge, so select number n is asserted by clearing bit n-1.
- R4: When one level write sets both bit 8+i and bit i, the set wins and level i becomes 1.
- R5: Pins with neither of their bits set in a level write keep their level, and without a level write strobe no level changes, whatever the data.
- R6: A configuration write stores bits 15..8 as the per-pin chip-select-use marks and bits 7..0 as the per-pin invert bits. The readback returns them in the same positions, and the marks appear on cs_mode.
- R7: Each pin drives its stored level XOR its invert bit.
- R8: Pins at or above the implemented count ignore all writes: level 1, configuration bits 0, pin output 1.
- R9: WIDE_VARIANT=1 implements 6 selects (pins 0..5) and WIDE_VARIANT=0 implements 3 (pins 0..2).
- R10: Writing the level word 0xFF00 sets every implemented level to 1, which releases every select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word: [15:8] chip-select-use marks, [7:0] invert bits |
| lvl_we | input | 1 | Level-control write strobe |
| lvl_wdata | input | 16 | Level word: [15:8] set bits, [7:0] clear bits |
| cfg_rdata | output | 16 | Configuration readback |
| lvl_status | output | PIN_COUNT | Current stored levels |
| cs_mode | output | PIN_COUNT | Per-pin chip-select-use marks |
| pin_out | output | PIN_COUNT | Pin outputs after inversion |

## Verification
The bench aims at the following corner cases:

- **Set and clear on the same pin in one write.** A design that let the clear win would leave that select asserted.
- **Untouched pins during a write.** Writes that touch only some pins check that the others hold their level. A design that wrote the whole byte back would release or assert selects nobody addressed.
- **Variant boundary.** The wide and narrow variants run side by side on the same stimulus. A design that forgot the implemented count would let pins 3..5 or 6..7 change, invert, or read back configuration bits.
- **Off-by-one select numbering.** Numbering from 1 is checked by asserting selects 1, 3 and 6 through bits 0, 2 and 5. An off-by-one mapping would move a pin next to the intended one.

// File: rtl/cs_pkg.sv
package cs_pkg;
   localparam int FIELD_W = 8;
   localparam int WORD_W  = 2 * FIELD_W;

   function automatic int active_count(input bit wide);
      return wide ? 6 : 3;
   endfunction
endpackage

// File: rtl/cs_cfg_reg.sv
module cs_cfg_reg
   import cs_pkg::*;
#(
   parameter int PIN_COUNT = 8,
   parameter int ACTIVE    = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [WORD_W-1:0]    wdata,
   output logic [PIN_COUNT-1:0] mode_q,
   output logic [PIN_COUNT-1:0] inv_q
);
   localparam logic [PIN_COUNT-1:0] KEEP = PIN_COUNT'((1 << ACTIVE) - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         inv_q  <= '0;
      end else if (we) begin
         mode_q <= wdata[FIELD_W +: PIN_COUNT] & KEEP;
         inv_q  <= wdata[0 +: PIN_COUNT] & KEEP;
      end
   end

   generate
      if (PIN_COUNT < FIELD_W) begin : g_spare
         logic unused_hi;
         assign unused_hi = &{1'b0, wdata[WORD_W-1:FIELD_W+PIN_COUNT],
                              wdata[FIELD_W-1:PIN_COUNT]};
      end
   endgenerate
endmodule

// File: rtl/cs_pin_cell.sv
module cs_pin_cell #(
   parameter bit IMPL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic we,
   input  logic set_b,
   input  logic clr_b,
   input  logic inv,
   output logic level,
   output logic pin
);
   generate
      if (IMPL) begin : g_live
         logic lvl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              lvl_q <= 1'b1;
            else if (we && set_b)    lvl_q <= 1'b1;
            else if (we && clr_b)    lvl_q <= 1'b0;
         end
         assign level = lvl_q;
         assign pin   = lvl_q ^ inv;
      end else begin : g_tied
         logic unused_in;
         assign unused_in = &{1'b0, clk, rst_n, we, set_b, clr_b, inv};
         assign level = 1'b1;
         assign pin   = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/cs_out_ctrl.sv
module cs_out_ctrl
   import cs_pkg::*;
#(
   parameter int PIN_COUNT    = 8,
   parameter bit WIDE_VARIANT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [15:0]          cfg_wdata,
   input  logic                 lvl_we,
   input  logic [15:0]          lvl_wdata,
   output logic [15:0]          cfg_rdata,
   output logic [PIN_COUNT-1:0] lvl_status,
   output logic [PIN_COUNT-1:0] cs_mode,
   output logic [PIN_COUNT-1:0] pin_out
);
   localparam int ACTIVE = active_count(WIDE_VARIANT);

   generate
      if (PIN_COUNT > FIELD_W || PIN_COUNT < 1) begin : g_bad_pins
         $error("cs_out_ctrl: PIN_COUNT must be 1..%0d", FIELD_W);
      end
      if (ACTIVE > PIN_COUNT) begin : g_bad_active
         $error("cs_out_ctrl: implemented selects exceed PIN_COUNT");
      end
   endgenerate

   logic [PIN_COUNT-1:0] mode_q;
   logic [PIN_COUNT-1:0] inv_q;

   cs_cfg_reg #(.PIN_COUNT(PIN_COUNT), .ACTIVE(ACTIVE)) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .wdata  (cfg_wdata),
      .mode_q (mode_q),
      .inv_q  (inv_q)
   );

   generate
      for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
         cs_pin_cell #(.IMPL(i < ACTIVE)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (lvl_we),
            .set_b (lvl_wdata[FIELD_W + i]),
            .clr_b (lvl_wdata[i]),
            .inv   (inv_q[i]),
            .level (lvl_status[i]),
            .pin   (pin_out[i])
         );
      end
      if (PIN_COUNT < FIELD_W) begin : g_spare
         logic unused_lvl;
         assign unused_lvl = &{1'b0, lvl_wdata[WORD_W-1:FIELD_W+PIN_COUNT],
                               lvl_wdata[FIELD_W-1:PIN_COUNT]};
      end
   endgenerate

   always_comb begin
      cfg_rdata = '0;
      cfg_rdata[FIELD_W +: PIN_COUNT] = mode_q;
      cfg_rdata[0 +: PIN_COUNT]       = inv_q;
   end

   assign cs_mode = mode_q;
endmodule

// File: rtl/cs_out_ctrl_chk.sv
module cs_out_ctrl_chk
   import cs_pkg::*;
#(
   parameter int PIN_COUNT    = 8,
   parameter bit WIDE_VARIANT = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 lvl_we,
   input logic [15:0]          lvl_wdata,
   input logic [15:0]          cfg_rdata,
   input logic [PIN_COUNT-1:0] lvl_status,
   input logic [PIN_COUNT-1:0] pin_out
);
   localparam int ACTIVE = active_count(WIDE_VARIANT);
   localparam logic [PIN_COUNT-1:0] LIVE = PIN_COUNT'((1 << ACTIVE) - 1);

   logic [PIN_COUNT-1:0] set_m, clr_m;
   assign set_m = lvl_wdata[FIELD_W +: PIN_COUNT] & LIVE;
   assign clr_m = lvl_wdata[0 +: PIN_COUNT] & LIVE & ~lvl_wdata[FIELD_W +: PIN_COUNT];

   assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_we |=> ((lvl_status & $past(set_m)) == $past(set_m)));

   assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_we |=> ((~lvl_status & $past(clr_m)) == $past(clr_m)));

   assert_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_we |=> (((lvl_status ^ $past(lvl_status)) &
                   ~$past(lvl_wdata[FIELD_W +: PIN_COUNT] | lvl_wdata[0 +: PIN_COUNT])) == '0));

   assert_no_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !lvl_we |=> $stable(lvl_status));

   assert_spare_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (((lvl_status & ~LIVE) == ~LIVE) && ((pin_out & ~LIVE) == ~LIVE) &&
       ((cfg_rdata[FIELD_W +: PIN_COUNT] & ~LIVE) == '0)));

   assert_invert_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pin_out == (lvl_status ^ cfg_rdata[0 +: PIN_COUNT]));
endmodule

bind cs_out_ctrl cs_out_ctrl_chk #(.PIN_COUNT(PIN_COUNT), .WIDE_VARIANT(WIDE_VARIANT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lvl_we     (lvl_we),
   .lvl_wdata  (lvl_wdata),
   .cfg_rdata  (cfg_rdata),
   .lvl_status (lvl_status),
   .pin_out    (pin_out)
);

// File: tb/cs_out_ctrl_tb.sv
`timescale 1ns/1ps
module cs_out_ctrl_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0, lvl_we = 1'b0;
   logic [15:0] cfg_wdata = '0, lvl_wdata = '0;
   logic [15:0] cfg_rd_w, cfg_rd_n;
   logic [7:0]  lvl_w, lvl_n, mode_w, mode_n, pin_w, pin_n;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   // reference state: index 0 = wide (6 selects), 1 = narrow (3 selects)
   int m_lvl[2], m_mode[2], m_inv[2];

   always #4 clk = ~clk;

   cs_out_ctrl #(.PIN_COUNT(8), .WIDE_VARIANT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .lvl_we(lvl_we), .lvl_wdata(lvl_wdata), .cfg_rdata(cfg_rd_w),
      .lvl_status(lvl_w), .cs_mode(mode_w), .pin_out(pin_w));

   cs_out_ctrl #(.PIN_COUNT(8), .WIDE_VARIANT(1'b0)) u_dut_narrow (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .lvl_we(lvl_we), .lvl_wdata(lvl_wdata), .cfg_rdata(cfg_rd_n),
      .lvl_status(lvl_n), .cs_mode(mode_n), .pin_out(pin_n));

   function automatic int nsel(int v);
      return (v == 0) ? 6 : 3;  // R9
   endfunction

   task automatic model_reset();
      for (int v = 0; v < 2; v++) begin
         m_lvl[v] = 8'hFF; m_mode[v] = 0; m_inv[v] = 0;
      end
   endtask

   task automatic model_step(bit cw, int cd, bit lw, int ld);
      for (int v = 0; v < 2; v++) begin
         int mask = (1 << nsel(v)) - 1;
         if (lw) begin
            for (int i = 0; i < nsel(v); i++) begin
               if ((ld >> (8 + i)) & 1)  m_lvl[v] = m_lvl[v] | (1 << i);
               else if ((ld >> i) & 1)   m_lvl[v] = m_lvl[v] & ~(1 << i);
            end
         end
         if (cw) begin
            m_mode[v] = (cd >> 8) & mask;
            m_inv[v]  = cd & mask;
         end
      end
   endtask

   task automatic cmp1(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare(string tag);
      cmp1(tag, "wide level",    int'(lvl_w),    m_lvl[0]);
      cmp1(tag, "wide pin",      int'(pin_w),    (m_lvl[0] ^ m_inv[0]) & 8'hFF);
      cmp1(tag, "wide cfg",      int'(cfg_rd_w), (m_mode[0] << 8) | m_inv[0]);
      cmp1(tag, "wide mode",     int'(mode_w),   m_mode[0]);
      cmp1(tag, "narrow level",  int'(lvl_n),    m_lvl[1]);
      cmp1(tag, "narrow pin",    int'(pin_n),    (m_lvl[1] ^ m_inv[1]) & 8'hFF);
      cmp1(tag, "narrow cfg",    int'(cfg_rd_n), (m_mode[1] << 8) | m_inv[1]);
      cmp1(tag, "narrow mode",   int'(mode_n),   m_mode[1]);
   endtask

   // called at a falling edge; returns at the next falling edge after comparing
   task automatic op(bit cw, int cd, bit lw, int ld, string tag);
      cfg_we = cw; cfg_wdata = 16'(cd); lvl_we = lw; lvl_wdata = 16'(ld);
      @(posedge clk);
      model_step(cw, cd, lw, ld);
      @(negedge clk);
      cfg_we = 1'b0; lvl_we = 1'b0;
      compare(tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      compare("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 after release");

      op(0, 0, 1, 16'h0001, "R3 select 1 -> bit0 cleared");
      op(0, 0, 1, 16'h0024, "R3 R8 R9 selects 3 and 6");
      op(0, 0, 1, 16'h0400, "R2 set bit2");
      op(0, 0, 1, 16'h0002, "R3 clear bit1");
      op(0, 0, 1, 16'h0202, "R4 set beats clear on bit1");
      op(0, 0, 1, 16'h0100, "R5 R2 only bit0 touched");
      op(1, 16'h0705, 0, 0, "R6 R7 cfg write");
      op(0, 0, 1, 16'h00FF, "R7 R3 clear all, inverted pins");
      op(1, 16'hFFFF, 0, 0, "R8 R9 cfg all ones");
      op(0, 0, 0, 16'h00FF, "R5 no strobe, data ignored");
      op(0, 0, 1, 16'hFF00, "R10 release all");
      op(1, 16'h0000, 1, 16'hC0C0, "R8 spare pin writes ignored");

      for (int k = 0; k < 300; k++) begin
         op(bit'($urandom_range(0, 3) == 0), int'($urandom_range(0, 16'hFFFF)),
            bit'($urandom_range(0, 1)), int'($urandom_range(0, 16'hFFFF)),
            "R2 R3 R4 R5 R7 random");
      end

      rst_n = 1'b0;
      model_reset();
      @(negedge clk);
      compare("R1 re-reset");
      finish_run();
   end
endmodule